// File: doc/BRIEF.md
# Voice Activity Wake Buffer

This block sits between an audio sample stream and memory during low-power sleep. While enabled it writes each incoming sample, unmodified, into a circular on-chip RAM, so that a pre-trigger history is always available. In parallel it removes the DC offset from each sample with a first-order high-pass filter and tracks the signal magnitude with a fast moving average. It also follows the background noise with a slower moving average. A wake interrupt is raised when the fast average has stood above the learned noise floor plus a programmed margin for a programmed number of consecutive samples.

When software clears the enable, every following sample is steered to a DMA output port instead of the RAM, and no sample is dropped at the switch. Software then reads the ring through a random-access read port, starting at the write pointer once the wrapped flag is set, to recover the history oldest first. The input is never stalled.

Top module: `vad_wake_buffer`

## Requirements
- R1: A sample with `smp_valid_i`=1 while `enable_i`=1 is written unmodified at address `wr_ptr_o`, and `wr_ptr_o` advances by one on that edge; otherwise `wr_ptr_o` holds.
- R2: After address DEPTH-1 is written the pointer returns to 0 and `wrapped_o` goes to 1, staying 1 until reset; later writes overwrite the oldest entries.
- R3: Each stored sample x passes a DC-blocking filter: with accumulator A (reset 0) and d = floor(A/2^HP_SH), the output is y = x - d and A becomes A + x - d; a constant input drives y to 0.
- R4: One edge after the filter stage, `level_o` becomes L + floor(|y|/2^EN_K) - floor(L/2^EN_K), where L is its previous value; it holds when no filtered sample arrives.
- R5: A filtered sample is "above" when the new level exceeds `floor_o` + `margin_i`; only when it is not above, `floor_o` F becomes F + floor(level/2^NF_K) - floor(F/2^NF_K) using the new level.
- R6: A run counter counts consecutive above samples (saturating at its maximum, reset to 0 by a non-above sample); `irq_o` sets on the edge where the count reaches `run_len_i` (0 is treated as 1).
- R7: `irq_o` is a level that stays 1 until a cycle with `irq_clr_i`=1 and no new detection; a detection in the same cycle wins over the clear.
- R8: A sample with `smp_valid_i`=1 while `enable_i`=0 appears on `dma_data_o` with `dma_valid_o`=1 on the next cycle, is not stored, and leaves the filter, level, floor and interrupt state unchanged.
- R9: `rd_data_o` presents the RAM word at `rd_addr_i` one edge after the address is applied, reading the content before any write on the same edge.
- R10: After reset, `irq_o`, `level_o`, `floor_o`, `wr_ptr_o`, `wrapped_o` and `dma_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | 1: buffer and detect; 0: steer stream to DMA port |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | DW | Signed sample |
| margin_i | input | DW+2 | Detection margin above noise floor |
| run_len_i | input | RUN_W | Consecutive above samples required |
| irq_clr_i | input | 1 | Clears the wake interrupt |
| irq_o | output | 1 | Wake interrupt level |
| level_o | output | DW+2 | Smoothed signal magnitude |
| floor_o | output | DW+2 | Learned noise floor |
| dma_valid_o | output | 1 | DMA sample strobe |
| dma_data_o | output | DW | DMA sample |
| rd_addr_i | input | log2(DEPTH) | Ring read address |
| rd_data_o | output | DW | Ring read data |
| wr_ptr_o | output | log2(DEPTH) | Next ring write address |
| wrapped_o | output | 1 | Ring has wrapped at least once |

## Verification
The ring pointer, the wrapped flag, the DMA port and the read data are due one rising edge after the sample or address is applied, while the level, floor and interrupt are due two edges after a stored sample because the filter output is registered first. The bench drives inputs on the falling edge, advances a reference model once per rising edge in the same order (detector stage consuming the previous filter output before the filter takes the new sample, RAM read before write), and compares every output on the next falling edge. Directed phases add an unreachable margin, a constant input that the filter must null, and an oldest-first drain of a wrapped ring.

// File: rtl/vad_pkg.sv
package vad_pkg;
  localparam int unsigned SMP_W     = 16;
  localparam int unsigned RING_D    = 32;
  localparam int unsigned HP_SHIFT  = 4;
  localparam int unsigned LVL_SHIFT = 3;
  localparam int unsigned FLR_SHIFT = 6;
  localparam int unsigned RUN_W     = 4;
endpackage

// File: rtl/vad_hpf.sv
module vad_hpf #(
  parameter int unsigned DW = 16,
  parameter int unsigned SH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  output logic [DW+1:0] out_data_o
);
  localparam int unsigned AW_ = DW + SH + 1;

  logic signed [AW_-1:0] acc_q;
  logic signed [DW-1:0]  x;
  logic signed [DW:0]    dc;
  logic signed [DW+1:0]  y;

  assign x  = $signed(in_data_i);
  assign dc = $signed(acc_q[DW+SH:SH]);   // floor(acc / 2^SH)
  assign y  = (DW+2)'(x) - (DW+2)'(dc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        acc_q      <= acc_q + AW_'(x) - AW_'(dc);
        out_data_o <= y;
      end
    end
  end

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o && $stable(out_data_o));
endmodule

// File: rtl/vad_ema.sv
module vad_ema #(
  parameter int unsigned W = 18,
  parameter int unsigned K = 3
) (
  input  logic [W-1:0] avg_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] avg_o
);
  logic [W:0] t;
  always_comb begin
    t     = {1'b0, avg_i} + {1'b0, (x_i >> K)} - {1'b0, (avg_i >> K)};
    avg_o = t[W-1:0];
  end
endmodule

// File: rtl/vad_detect.sv
module vad_detect #(
  parameter int unsigned DW    = 16,
  parameter int unsigned LVL_K = 3,
  parameter int unsigned FLR_K = 6,
  parameter int unsigned RW    = 4,
  localparam int unsigned EW   = DW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hp_valid_i,
  input  logic [DW+1:0] hp_data_i,
  input  logic [EW-1:0] margin_i,
  input  logic [RW-1:0] run_len_i,
  input  logic          irq_clr_i,
  output logic          irq_o,
  output logic [EW-1:0] level_o,
  output logic [EW-1:0] floor_o
);
  logic signed [DW+1:0] y;
  logic [EW-1:0] mag, lvl_q, flr_q, lvl_nxt, flr_nxt;
  logic [EW:0]   thresh;
  logic [RW-1:0] run_q, run_nxt, need;
  logic          above, hit, irq_q;

  assign y   = $signed(hp_data_i);
  assign mag = y[DW+1] ? EW'(-y) : EW'(y);

  vad_ema #(.W(EW), .K(LVL_K)) u_lvl (.avg_i(lvl_q), .x_i(mag),     .avg_o(lvl_nxt));
  vad_ema #(.W(EW), .K(FLR_K)) u_flr (.avg_i(flr_q), .x_i(lvl_nxt), .avg_o(flr_nxt));

  always_comb begin
    thresh  = {1'b0, flr_q} + {1'b0, margin_i};
    above   = {1'b0, lvl_nxt} > thresh;
    run_nxt = above ? ((&run_q) ? run_q : run_q + 1'b1) : '0;
    need    = (run_len_i == '0) ? RW'(1) : run_len_i;
    hit     = hp_valid_i && above && (run_nxt >= need);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      flr_q <= '0;
      run_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (hp_valid_i) begin
        lvl_q <= lvl_nxt;
        run_q <= run_nxt;
        if (!above) flr_q <= flr_nxt;   // learn only while quiet
      end
      if (hit)            irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign irq_o   = irq_q;
  assign level_o = lvl_q;
  assign floor_o = flr_q;

  assert_level_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hp_valid_i |=> $stable(lvl_q));
  assert_floor_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_valid_i && above) |=> $stable(flr_q));
  assert_no_spurious_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hp_valid_i && !irq_q) |=> !irq_q);
  assert_irq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
endmodule

// File: rtl/vad_ring.sv
module vad_ring #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic          wrapped_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q;
  logic          wrap_q;
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[ptr_q] <= wr_data_i;
    rd_q <= mem[rd_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else if (wr_en_i) begin
      if (ptr_q == LAST) begin
        ptr_q  <= '0;
        wrap_q <= 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign rd_data_o = rd_q;
  assign wr_ptr_o  = ptr_q;
  assign wrapped_o = wrap_q;

  assert_ptr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ptr_q));
  assert_wrap_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ptr_q == LAST) |=> wrap_q && ptr_q == '0);
  assert_wrap_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |=> wrap_q);
endmodule

// File: rtl/vad_wake_buffer.sv
module vad_wake_buffer
  import vad_pkg::*;
#(
  parameter int unsigned DW     = SMP_W,
  parameter int unsigned DEPTH  = RING_D,
  parameter int unsigned HP_SH  = HP_SHIFT,
  parameter int unsigned LVL_K  = LVL_SHIFT,
  parameter int unsigned FLR_K  = FLR_SHIFT,
  parameter int unsigned RW     = RUN_W,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned EW    = DW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_data_i,
  input  logic [EW-1:0] margin_i,
  input  logic [RW-1:0] run_len_i,
  input  logic          irq_clr_i,
  output logic          irq_o,
  output logic [EW-1:0] level_o,
  output logic [EW-1:0] floor_o,
  output logic          dma_valid_o,
  output logic [DW-1:0] dma_data_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic          wrapped_o
);
  logic          take, steer, hp_valid;
  logic [DW+1:0] hp_data;

  assign take  = enable_i & smp_valid_i;
  assign steer = ~enable_i & smp_valid_i;

  vad_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
    .clk_i, .rst_ni,
    .wr_en_i   (take),
    .wr_data_i (smp_data_i),
    .rd_addr_i,
    .rd_data_o,
    .wr_ptr_o,
    .wrapped_o
  );

  vad_hpf #(.DW(DW), .SH(HP_SH)) u_hpf (
    .clk_i, .rst_ni,
    .in_valid_i  (take),
    .in_data_i   (smp_data_i),
    .out_valid_o (hp_valid),
    .out_data_o  (hp_data)
  );

  vad_detect #(.DW(DW), .LVL_K(LVL_K), .FLR_K(FLR_K), .RW(RW)) u_det (
    .clk_i, .rst_ni,
    .hp_valid_i (hp_valid),
    .hp_data_i  (hp_data),
    .margin_i,
    .run_len_i,
    .irq_clr_i,
    .irq_o,
    .level_o,
    .floor_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_valid_o <= 1'b0;
      dma_data_o  <= '0;
    end else begin
      dma_valid_o <= steer;
      if (steer) dma_data_o <= smp_data_i;
    end
  end

  assert_dma_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !dma_valid_o);
  assert_no_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steer |=> $stable(wr_ptr_o));
  assert_dma_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steer |=> dma_data_o == $past(smp_data_i));
endmodule

// File: tb/tb_vad_wake_buffer.sv
module tb_vad_wake_buffer;
  localparam int DW = 16, DEPTH = 32, AW = 5, EW = 18, RW = 4;
  localparam int HP = 4, LK = 3, FK = 6;

  logic clk = 0, rst_ni = 0;
  logic enable = 0, valid = 0, clr = 0;
  logic [DW-1:0] data = '0;
  logic [EW-1:0] margin = '0;
  logic [RW-1:0] run_len = '0;
  logic [AW-1:0] rd_addr = '0;
  logic irq, dma_v, wrapped;
  logic [EW-1:0] level, flr;
  logic [DW-1:0] dma_d, rd_d;
  logic [AW-1:0] wp;

  always #4 clk = ~clk;

  vad_wake_buffer dut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable), .smp_valid_i(valid),
    .smp_data_i(data), .margin_i(margin), .run_len_i(run_len), .irq_clr_i(clr),
    .irq_o(irq), .level_o(level), .floor_o(flr), .dma_valid_o(dma_v),
    .dma_data_o(dma_d), .rd_addr_i(rd_addr), .rd_data_o(rd_d),
    .wr_ptr_o(wp), .wrapped_o(wrapped)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  longint m_acc = 0, m_hy = 0, m_lvl = 0, m_flr = 0;
  bit m_hv = 0, m_irq = 0, m_wrap = 0, m_dv = 0, m_rok = 0;
  int m_run = 0, m_wp = 0;
  logic [DW-1:0] m_mem [DEPTH];
  bit m_wr [DEPTH];
  logic [DW-1:0] m_dd = '0, m_rd = '0;
  logic [DW-1:0] hist [$];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint ema(longint avg, longint x, int k);
    return avg + (x >>> k) - (avg >>> k);
  endfunction

  task automatic model_step();
    bit take, above, hit;
    longint a, ln, x, d;
    int need;
    hit = 0;
    take = enable && valid;
    if (m_hv) begin   // detector consumes previous filter output (R4-R6)
      a = (m_hy < 0) ? -m_hy : m_hy;
      ln = ema(m_lvl, a, LK);
      above = ln > (m_flr + longint'(margin));
      m_run = above ? ((m_run == 15) ? 15 : m_run + 1) : 0;
      need = (run_len == 0) ? 1 : int'(run_len);
      hit = above && (m_run >= need);
      if (!above) m_flr = ema(m_flr, ln, FK);
      m_lvl = ln;
    end
    if (hit) m_irq = 1; else if (clr) m_irq = 0;
    m_hv = take;      // R3 filter stage
    if (take) begin
      x = longint'($signed(data));
      d = m_acc >>> HP;
      m_hy = x - d;
      m_acc = m_acc + x - d;
    end
    m_rd = m_mem[rd_addr];   // R9 read before write
    m_rok = m_wr[rd_addr];
    if (take) begin
      m_mem[m_wp] = data;
      m_wr[m_wp] = 1;
      hist.push_back(data);
      if (m_wp == DEPTH - 1) begin m_wp = 0; m_wrap = 1; end
      else m_wp++;
    end
    m_dv = valid && !enable;
    if (m_dv) m_dd = data;
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(irq == m_irq, "R6 R7 irq", irq, m_irq);
    chk(level == EW'(m_lvl), "R3 R4 level", level, m_lvl);
    chk(flr == EW'(m_flr), "R5 floor", flr, m_flr);
    chk(wp == AW'(m_wp), "R1 wr_ptr", wp, m_wp);
    chk(wrapped == m_wrap, "R2 wrapped", wrapped, m_wrap);
    chk(dma_v == m_dv, "R8 dma_valid", dma_v, m_dv);
    if (m_dv) chk(dma_d == m_dd, "R8 dma_data", dma_d, m_dd);
    if (m_rok) chk(rd_d == m_rd, "R9 rd_data", rd_d, m_rd);
  endtask

  function automatic logic [DW-1:0] noise(int amp);
    int v;
    v = int'($urandom_range(2 * amp)) - amp;
    return DW'(v);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin m_wr[i] = 0; m_mem[i] = '0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(irq == 0 && dma_v == 0 && wrapped == 0, "R10 reset flags", {irq, dma_v, wrapped}, 0);
    chk(level == 0 && flr == 0 && wp == 0, "R10 reset state", level + flr + wp, 0);
    rst_ni = 1;
    @(negedge clk);

    // quiet learning
    enable = 1; margin = 18'd300; run_len = 4'd3;
    for (int i = 0; i < 200; i++) begin
      valid = ($urandom_range(3) != 0); data = noise(40);
      rd_addr = AW'($urandom); step();
    end
    // loud burst
    for (int i = 0; i < 20; i++) begin
      valid = 1; data = noise(20000); step();
    end
    chk(irq == 1, "R6 burst wakes", irq, 1);
    // clear while quiet for the filter to settle
    valid = 0; clr = 1; step(); clr = 0;
    for (int i = 0; i < 100; i++) begin valid = 1; data = noise(30); step(); end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(15) == 0) enable = ~enable;
      valid = ($urandom_range(4) != 0);
      data = ($urandom_range(9) == 0) ? noise(25000) : noise(60);
      clr = ($urandom_range(31) == 0);
      rd_addr = AW'($urandom);
      if ($urandom_range(99) == 0) run_len = RW'($urandom);
      if ($urandom_range(99) == 0) margin = EW'($urandom_range(2000));
      step();
    end
    clr = 0; enable = 1; run_len = 4'd3;

    // R6 unreachable margin: no wake
    margin = '1; valid = 0; clr = 1; step(); clr = 0;
    for (int i = 0; i < 30; i++) begin valid = 1; data = noise(30000); step(); end
    chk(irq == 0, "R6 unreachable margin", irq, 0);

    // R3 constant input nulled by the filter
    for (int i = 0; i < 500; i++) begin valid = 1; data = 16'd1200; step(); end
    chk(level < 8, "R3 dc removed", level, 7);

    // R8 disable: stream goes to DMA
    enable = 0;
    for (int i = 0; i < 8; i++) begin valid = 1; data = noise(1000); step(); end
    chk(wp == AW'(m_wp) && wrapped == 1, "R2 R8 ring untouched", wp, m_wp);

    // R9 drain oldest first
    valid = 0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [DW-1:0] exp_d;
      rd_addr = AW'((m_wp + i) % DEPTH);
      exp_d = hist[hist.size() - DEPTH + i];
      step();
      chk(rd_d == exp_d, "R9 drain order", rd_d, exp_d);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule